// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This block holds the status and interrupt flags of one serial transceiver's transmit side and its modem input. It watches the active-low clear-to-send pin and a line-break detect pulse. It also watches the full and empty states of the transmit queue, queue flush requests, the transmitter enable, and the shifter's busy and frame-done indications. From these it builds a five-bit status word and a single interrupt line.

Software clears the sticky flags by writing a mask with one bit per flag. A 1 in the mask clears that flag and a 0 leaves it alone. A write to the transmit data register also clears the transmit-complete flag, without any use of the mask. Each of the four flags has its own interrupt-enable bit. The interrupt line is the OR of every flag that is 1 and enabled.

The status word is laid out as follows:

| Bit | Flag |
|-----|------|
| 0 | transmit complete |
| 1 | queue not full |
| 2 | line break seen |
| 3 | clear-to-send changed |
| 4 | clear-to-send level |

The clear mask and the interrupt enables use the same positions for bits 3 to 0.

Top module: `sio_flag_unit`

## Requirements
- R1: Status bit 4 equals the inverse of `cts_n_i` as seen through a `SYNC_STAGES`-flop synchronizer. A pin change shows up after `SYNC_STAGES` rising edges. The pin level is 1 while in reset.
- R2: Status bit 3 is set one edge after each synchronized clear-to-send transition, but only when `fc_en_i` is 1 on that edge. A transition while `fc_en_i` is 0 is lost.
- R3: Status bits 3 and 2 clear only on a `clr_wr_i` cycle whose `clr_mask_i` has a 1 at their own position. Mask bit 1, a mask of 0, and `tdr_wr_i` leave them unchanged.
- R4: A `brk_det_i` pulse sets status bit 2 on the next edge.
- R5: Status bit 1 is 0 whenever `txq_full_i` is 1, and 1 when the queue is not full and no flush is pending.
- R6: From a `txq_flush_i` cycle with the queue not empty, status bit 1 stays 0 until `txq_empty_i` is 1. It rises combinationally in the cycle empty rises. A flush while the queue is already empty has no effect.
- R7: Status bit 0 is set on the edge after a `frame_done_i` cycle in which `txq_empty_i` is 1. If the queue is not empty in that cycle, the flag is not set.
- R8: Status bit 0 clears on the edge after `clr_wr_i` with `clr_mask_i[0]`=1, or after any `tdr_wr_i`.
- R9: Status bit 0 is forced to 1 on every edge where `tx_en_i` is 0 and `tx_busy_i` is 0.
- R10: When a set event and a clear for the same flag fall on the same edge, the flag ends at 1.
- R11: `irq_o` is 1 exactly when some status bit 3..0 is 1 and its `irq_en_i` bit at the same position is 1.
- R12: After reset every flag is 0, except queue-not-full, which follows R5 with no flush pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| fc_en_i | input | 1 | Flow-control enable; arms the change flag |
| brk_det_i | input | 1 | Line-break detected pulse |
| txq_full_i | input | 1 | Transmit queue full |
| txq_empty_i | input | 1 | Transmit queue empty |
| txq_flush_i | input | 1 | Transmit queue flush request pulse |
| tx_en_i | input | 1 | Transmitter enable |
| tx_busy_i | input | 1 | A frame is being shifted out |
| frame_done_i | input | 1 | A data frame finished shifting, one-cycle pulse |
| clr_wr_i | input | 1 | Write strobe for the clear mask |
| clr_mask_i | input | 4 | Clear mask, 1 clears the flag at that position |
| tdr_wr_i | input | 1 | Write strobe to the transmit data register |
| irq_en_i | input | 4 | Per-flag interrupt enables |
| status_o | output | 5 | Status word, layout above |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are edges where a hardware set and a software clear land together. The clear can come from the mask or from the data-register side path, and the set can be the forced transmit-complete of a disabled transmitter. A second hard case is a flush whose empty indication arrives while the queue still reports full on earlier cycles. The stimulus reaches both on purpose, with directed collisions for each flag. It then runs a long stretch of independently randomized strobes, where such coincidences recur many times. A behavioural model tracks every flag on every cycle.

// File: rtl/sio_flag_pkg.sv
// Package: bit positions and shared types for the serial status flag unit.
// Assumes: the status word places the four sticky/derived flags in the low
// bits, and clear masks and interrupt enables share those positions.
package sio_flag_pkg;
    localparam int NFLAG   = 4;
    localparam int STAT_W  = NFLAG + 1;
    localparam int F_TC    = 0;
    localparam int F_TXNF  = 1;
    localparam int F_BRK   = 2;
    localparam int F_CTSC  = 3;
    localparam int F_CTS   = 4;

    typedef logic [NFLAG-1:0]  flag_vec_t;
    typedef logic [STAT_W-1:0] stat_vec_t;
endpackage

// File: rtl/sio_cts_sync.sv
// Module: sio_cts_sync
// Brings the asynchronous active-low clear-to-send pin into the clock domain
// through a STAGES-deep flop chain and reports its active-high level plus a
// one-cycle pulse for each synchronized transition.
// Assumes: STAGES >= 2; the pin idles high (deasserted) during reset.
module sio_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic level_o,
    output logic toggle_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchronizer chain, stage 0 samples the raw pin.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= pin_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    // Previous synchronized value, for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[STAGES-1];
    end

    // Active-high level and transition pulse.
    always_comb begin
        level_o  = ~chain_q[STAGES-1];
        toggle_o = chain_q[STAGES-1] ^ last_q;
    end
endmodule

// File: rtl/sio_sticky_flag.sv
// Module: sio_sticky_flag
// One sticky status bit: a set request raises it, a clear request lowers it,
// and a set on the same edge as a clear wins so no event is lost.
// Assumes: set_i and clr_i are synchronous to clk.
module sio_sticky_flag #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_q;

    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_q <= RESET_VAL;
        else if (set_i) q_q <= 1'b1;
        else if (clr_i) q_q <= 1'b0;
    end

    assign q_o = q_q;
endmodule

// File: rtl/sio_txq_track.sv
// Module: sio_txq_track
// Derives the queue-not-full flag. A flush request on a non-empty queue
// holds the flag low until the queue reports empty; the flag then rises in
// that same cycle, together with the empty indication.
// Assumes: txq_empty_i and txq_full_i are never both 1.
module sio_txq_track (
    input  logic clk,
    input  logic rst_n,
    input  logic txq_full_i,
    input  logic txq_empty_i,
    input  logic txq_flush_i,
    output logic not_full_o
);
    logic flush_pend_q;
    logic hold_low;

    // Remember an outstanding flush until the queue drains.
    always_ff @(posedge clk) begin
        if (!rst_n)           flush_pend_q <= 1'b0;
        else if (txq_empty_i) flush_pend_q <= 1'b0;
        else if (txq_flush_i) flush_pend_q <= 1'b1;
    end

    // Not-full is suppressed while a flush is outstanding and data remains.
    always_comb begin
        hold_low   = (flush_pend_q | txq_flush_i) & ~txq_empty_i;
        not_full_o = ~txq_full_i & ~hold_low;
    end
endmodule

// File: rtl/sio_flag_unit.sv
// Module: sio_flag_unit (top)
// Status and interrupt flag unit for a serial transceiver. It combines a
// synchronized clear-to-send level and change flag, a line-break flag, a
// queue-not-full flag and a transmit-complete flag into one status word, and
// ORs the enabled flags into one interrupt.
// Assumes: all inputs except cts_n_i are synchronous to clk; strobes are
// one-cycle pulses.
module sio_flag_unit
    import sio_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_n_i,
    input  logic              fc_en_i,
    input  logic              brk_det_i,
    input  logic              txq_full_i,
    input  logic              txq_empty_i,
    input  logic              txq_flush_i,
    input  logic              tx_en_i,
    input  logic              tx_busy_i,
    input  logic              frame_done_i,
    input  logic              clr_wr_i,
    input  logic [NFLAG-1:0]  clr_mask_i,
    input  logic              tdr_wr_i,
    input  logic [NFLAG-1:0]  irq_en_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    logic      cts_level;
    logic      cts_toggle;
    flag_vec_t flags;
    flag_vec_t set_req;
    flag_vec_t clr_req;

    sio_cts_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n_i  (cts_n_i),
        .level_o  (cts_level),
        .toggle_o (cts_toggle)
    );

    sio_txq_track u_txq_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .txq_full_i  (txq_full_i),
        .txq_empty_i (txq_empty_i),
        .txq_flush_i (txq_flush_i),
        .not_full_o  (flags[F_TXNF])
    );

    // Hardware set and software clear requests per sticky flag.
    always_comb begin
        set_req          = '0;
        clr_req          = '0;
        set_req[F_CTSC]  = cts_toggle & fc_en_i;
        set_req[F_BRK]   = brk_det_i;
        set_req[F_TC]    = (frame_done_i & txq_empty_i) | (~tx_en_i & ~tx_busy_i);
        clr_req[F_CTSC]  = clr_wr_i & clr_mask_i[F_CTSC];
        clr_req[F_BRK]   = clr_wr_i & clr_mask_i[F_BRK];
        clr_req[F_TC]    = (clr_wr_i & clr_mask_i[F_TC]) | tdr_wr_i;
    end

    // One sticky register per flag; the queue-not-full position is derived.
    generate
        for (genvar f = 0; f < NFLAG; f++) begin : g_flag
            if (f != F_TXNF) begin : g_sticky
                sio_sticky_flag #(.RESET_VAL(1'b0)) u_flag (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .set_i (set_req[f]),
                    .clr_i (clr_req[f]),
                    .q_o   (flags[f])
                );
            end
        end
    endgenerate

    // Status word assembly and interrupt combine.
    always_comb begin
        status_o               = '0;
        status_o[NFLAG-1:0]    = flags;
        status_o[F_CTS]        = cts_level;
        irq_o                  = |(flags & irq_en_i);
    end
endmodule

// File: rtl/sio_flag_unit_chk.sv
// Module: sio_flag_unit_chk
// Checker for sio_flag_unit, attached by bind. Relates the input strobes to
// the status word and interrupt over time.
// Assumes: the default position layout of sio_flag_pkg.
module sio_flag_unit_chk
    import sio_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cts_n_i,
    input logic              brk_det_i,
    input logic              txq_full_i,
    input logic              txq_empty_i,
    input logic              txq_flush_i,
    input logic              tx_en_i,
    input logic              tx_busy_i,
    input logic              frame_done_i,
    input logic              clr_wr_i,
    input logic [NFLAG-1:0]  clr_mask_i,
    input logic              tdr_wr_i,
    input logic [NFLAG-1:0]  irq_en_i,
    input logic [STAT_W-1:0] status_o,
    input logic              irq_o
);
    logic [3:0] since_rst_q;
    logic       pin_steady;

    // Cycles since reset, saturating, to gate the synchronizer check.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst_q <= '0;
        else if (since_rst_q != 4'hF) since_rst_q <= since_rst_q + 4'd1;
    end

    // Tracks whether the pin has held one level for SYNC_STAGES+1 samples.
    logic [SYNC_STAGES:0] pin_hist_q;
    always_ff @(posedge clk) begin
        if (!rst_n) pin_hist_q <= '1;
        else        pin_hist_q <= {pin_hist_q[SYNC_STAGES-1:0], cts_n_i};
    end
    assign pin_steady = (&pin_hist_q) | ~(|pin_hist_q);

    AST_CTS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q > SYNC_STAGES[3:0]) && pin_steady |-> status_o[F_CTS] == ~pin_hist_q[0]); // R1
    AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det_i |=> status_o[F_BRK]); // R4
    AST_NF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        txq_full_i |-> !status_o[F_TXNF]); // R5
    AST_NF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        txq_flush_i && !txq_empty_i |-> !status_o[F_TXNF]); // R6
    AST_NF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        txq_empty_i && !txq_full_i |-> status_o[F_TXNF]); // R6
    AST_TC_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i && !tx_busy_i |=> status_o[F_TC]); // R9
    AST_TC_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_i && txq_empty_i |=> status_o[F_TC]); // R7
    AST_TC_WRCLR: assert property (@(posedge clk) disable iff (!rst_n)
        tdr_wr_i && tx_en_i && !frame_done_i |=> !status_o[F_TC]); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en_i == '0 |-> !irq_o); // R11
    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[F_BRK] && !(clr_wr_i && clr_mask_i[F_BRK]) |=> status_o[F_BRK]); // R3
endmodule

bind sio_flag_unit sio_flag_unit_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/sio_flag_unit_tb.sv
// Bench for sio_flag_unit: directed collisions plus a randomized stretch,
// compared every cycle against a behavioural model.
module sio_flag_unit_tb_top;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n_i = 1'b1, fc_en_i = 1'b0, brk_det_i = 1'b0;
    logic       txq_full_i = 1'b0, txq_empty_i = 1'b1, txq_flush_i = 1'b0;
    logic       tx_en_i = 1'b1, tx_busy_i = 1'b0, frame_done_i = 1'b0;
    logic       clr_wr_i = 1'b0, tdr_wr_i = 1'b0;
    logic [3:0] clr_mask_i = '0, irq_en_i = '0;
    logic [4:0] status_o;
    logic       irq_o;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit started = 0;

    // model state
    int  pin_hist[0:SYNC];
    bit  m_ctsc, m_brk, m_tc, m_pend;

    always #4 clk = ~clk;

    sio_flag_unit #(.SYNC_STAGES(SYNC)) dut_i (.*);

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Model update at each rising edge.
    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i <= SYNC; i++) pin_hist[i] = 1;
            m_ctsc = 0; m_brk = 0; m_tc = 0; m_pend = 0;
        end else begin
            bit tgl;
            tgl = (pin_hist[SYNC-1] != pin_hist[SYNC]);
            if (tgl && fc_en_i) m_ctsc = 1;
            else if (clr_wr_i && clr_mask_i[3]) m_ctsc = 0;
            if (brk_det_i) m_brk = 1;
            else if (clr_wr_i && clr_mask_i[2]) m_brk = 0;
            if ((frame_done_i && txq_empty_i) || (!tx_en_i && !tx_busy_i)) m_tc = 1;
            else if ((clr_wr_i && clr_mask_i[0]) || tdr_wr_i) m_tc = 0;
            if (txq_empty_i) m_pend = 0;
            else if (txq_flush_i) m_pend = 1;
            for (int i = SYNC; i > 0; i--) pin_hist[i] = pin_hist[i-1];
            pin_hist[0] = cts_n_i;
        end
    end

    // Compare every cycle at the falling edge.
    always @(negedge clk) begin
        if (started) begin
            bit nf;
            bit [3:0] fl;
            nf = !txq_full_i && !((m_pend || txq_flush_i) && !txq_empty_i);
            fl = {m_ctsc, m_brk, nf, m_tc};
            check_bit("R1", "cts level", status_o[4], pin_hist[SYNC-1] == 0);
            check_bit("R2/R3", "cts change", status_o[3], m_ctsc);
            check_bit("R4/R3", "break", status_o[2], m_brk);
            check_bit("R5/R6", "queue not full", status_o[1], nf);
            check_bit("R7/R8/R9", "tx complete", status_o[0], m_tc);
            check_bit("R11", "irq", irq_o, |(fl & irq_en_i));
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_clear(input logic [3:0] m);
        clr_wr_i = 1; clr_mask_i = m; step(); clr_wr_i = 0; clr_mask_i = '0;
    endtask

    initial begin
        step(3);
        // R12: reset state, checked against the model during and after reset
        check_bit("R12", "reset status", status_o == 5'b00010, 1'b1);
        rst_n = 1; step(2);
        irq_en_i = 4'hF;

        // R1/R2: toggles with flow control off then on
        cts_n_i = 0; step(4);
        check_bit("R2", "no change flag without fc", status_o[3], 1'b0);
        fc_en_i = 1; cts_n_i = 1; step(4);
        check_bit("R2", "change flag with fc", status_o[3], 1'b1);
        // R3: wrong clear bits and data writes leave it
        pulse_clear(4'b0010); tdr_wr_i = 1; step(); tdr_wr_i = 0;
        check_bit("R3", "change flag kept", status_o[3], 1'b1);
        pulse_clear(4'b1000);
        check_bit("R3", "change flag cleared", status_o[3], 1'b0);

        // R4/R10: break set colliding with its clear
        brk_det_i = 1; clr_wr_i = 1; clr_mask_i = 4'b0100; step();
        brk_det_i = 0; clr_wr_i = 0; clr_mask_i = '0;
        check_bit("R10", "break set wins", status_o[2], 1'b1);
        pulse_clear(4'b0100);
        check_bit("R3", "break cleared", status_o[2], 1'b0);

        // R5/R6: full then flush draining over several cycles
        txq_empty_i = 0; step(); txq_full_i = 1; step();
        check_bit("R5", "full lowers not-full", status_o[1], 1'b0);
        txq_full_i = 0; txq_flush_i = 1; step(); txq_flush_i = 0; step(3);
        check_bit("R6", "held through flush", status_o[1], 1'b0);
        txq_empty_i = 1; #1;
        check_bit("R6", "rises with empty", status_o[1], 1'b1);
        step(); txq_flush_i = 1; step(); txq_flush_i = 0;
        check_bit("R6", "flush when empty no effect", status_o[1], 1'b1);

        // R7/R8: frame completion and clears
        tdr_wr_i = 1; step(); tdr_wr_i = 0;
        check_bit("R8", "data write clears tc", status_o[0], 1'b0);
        txq_empty_i = 0; frame_done_i = 1; step(); frame_done_i = 0;
        check_bit("R7", "no tc with data left", status_o[0], 1'b0);
        txq_empty_i = 1; frame_done_i = 1; step(); frame_done_i = 0;
        check_bit("R7", "tc on last frame", status_o[0], 1'b1);
        frame_done_i = 1; tdr_wr_i = 1; step(); frame_done_i = 0; tdr_wr_i = 0;
        check_bit("R10", "tc set wins over data write", status_o[0], 1'b1);
        pulse_clear(4'b0001);
        check_bit("R8", "mask clears tc", status_o[0], 1'b0);

        // R9: disabled transmitter, busy then idle
        tx_en_i = 0; tx_busy_i = 1; step();
        check_bit("R9", "no force while busy", status_o[0], 1'b0);
        tx_busy_i = 0; step(); pulse_clear(4'b0001);
        check_bit("R9", "forced despite clear", status_o[0], 1'b1);
        tx_en_i = 1;

        // R11: each enable alone
        for (int b = 0; b < 4; b++) begin
            irq_en_i = 4'b1 << b; step();
        end
        irq_en_i = 4'hF;

        // Randomized stretch
        for (int i = 0; i < 4000; i++) begin
            cts_n_i      = ($urandom_range(0, 7) == 0) ? ~cts_n_i : cts_n_i;
            fc_en_i      = $urandom_range(0, 3) != 0;
            brk_det_i    = $urandom_range(0, 9) == 0;
            txq_full_i   = $urandom_range(0, 5) == 0;
            txq_empty_i  = !txq_full_i && ($urandom_range(0, 3) == 0);
            txq_flush_i  = $urandom_range(0, 9) == 0;
            tx_en_i      = $urandom_range(0, 7) != 0;
            tx_busy_i    = $urandom_range(0, 1) == 0;
            frame_done_i = $urandom_range(0, 5) == 0;
            clr_wr_i     = $urandom_range(0, 3) == 0;
            clr_mask_i   = 4'($urandom);
            tdr_wr_i     = $urandom_range(0, 6) == 0;
            irq_en_i     = 4'($urandom);
            step();
        end
        finish_run();
    end
endmodule